// File: doc/BRIEF.md
# LIN Master Header Generator

This block drives the header portion of a LIN frame onto a UART transmit line when a send request arrives. A header always begins with a break, which holds the line low for a programmable number of bit times. Depending on the header-select code, the break may be followed by a high delimiter and the 0x55 synchronisation byte, and then optionally by the protected identifier byte. The identifier's two top bits can come straight from the supplied byte, or the block can compute them as the standard LIN parity bits.

Bit timing comes from an oversampling tick. One bit lasts `OVS` tick pulses. Once a transmission starts, the send bit stays high until the last bit of the chosen header has been sent. It then clears itself, and a one-cycle done pulse marks the end. While a header is on the line, the block reads back the receive line at mid-bit and compares it with the level it is driving. Any disagreement sets a sticky bit-error flag, which stays set until a clear pulse removes it.

Top module: `lin_hdr_gen`

## Requirements
- R1: After synchronous reset, tx_out is 1 and send_busy, done and bit_err are all 0.
- R2: A send_set pulse while idle with hdr_sel equal to 0, 1 or 2 sets send_busy and drives tx_out low on the next cycle. hdr_sel = 3 is receive-only: a send_set pulse with this code leaves send_busy at 0 and tx_out at 1.
- R3: The break holds tx_out at 0 for brk_len+1 bit times, where one bit time is OVS bit_tick pulses.
- R4: With hdr_sel = 1 or 2, a high delimiter of dlm_len+1 bit times follows the break (codes 0..3 give 1..4 bits). With hdr_sel = 0 the header ends right after the break, with no delimiter.
- R5: With hdr_sel = 1 or 2, the delimiter is followed by a 10-bit sync frame: a start bit at 0, then 0x55 sent LSB first, then a stop bit at 1.
- R6: With hdr_sel = 2 only, a 10-bit identifier frame follows the sync frame: a start bit at 0, then the identifier byte starting from bit 0, then a stop bit at 1.
- R7: With par_en = 1, bits 6 and 7 of the sent identifier are P0 = ID0^ID1^ID2^ID4 and P1 = ~(ID1^ID3^ID4^ID5). With par_en = 0, all 8 bits of pid_in are sent unchanged.
- R8: When the last bit of the header ends, send_busy falls and done is high for exactly one cycle. tx_out stays 1 whenever the block is idle.
- R9: While send_busy is high, if rx_in differs from tx_out at mid-bit, bit_err is set and then holds until it is cleared. Mismatches while idle have no effect.
- R10: A pulse on err_clr clears bit_err when no new mismatch is being recorded in the same cycle.
- R11: A send_set pulse while a header is in progress is ignored: the header keeps its length and content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | Oversampling tick; OVS ticks make one bit |
| hdr_sel | input | 2 | Header content: 0 break, 1 +sync, 2 +identifier, 3 receive-only |
| brk_len | input | 4 | Break length minus one, in bit times |
| dlm_len | input | 2 | Delimiter length minus one, in bit times |
| pid_in | input | 8 | Identifier byte, bit 0 sent first |
| par_en | input | 1 | Replace bits 7:6 with computed parity |
| send_set | input | 1 | Request to start a header |
| err_clr | input | 1 | Clear bit_err |
| rx_in | input | 1 | Receive line readback |
| tx_out | output | 1 | Transmit line |
| send_busy | output | 1 | Send bit; clears itself at header end |
| done | output | 1 | One-cycle pulse at header end |
| bit_err | output | 1 | Sticky readback mismatch flag |

## Verification
The bench builds the block with OVS = 4 and holds bit_tick high, so each bit lasts four clocks. This makes the 16-bit break, the 4-bit delimiter and complete identifier headers short enough to cover many times within the run. A scoreboard predicts every header bit from the requirements, including the parity bits. The bench also checks receive-only rejection, retriggering during a header, and error injection on the loopback line both while idle and while transmitting.

// File: rtl/lin_hdr_pkg.sv
package lin_hdr_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_BRK, ST_DLM, ST_SYN, ST_PID} hdr_st_t;

  localparam logic [1:0] SEL_BRK    = 2'd0;
  localparam logic [1:0] SEL_SYN    = 2'd1;
  localparam logic [1:0] SEL_PID    = 2'd2;
  localparam logic [1:0] SEL_RXONLY = 2'd3;
  localparam logic [7:0] SYNC_BYTE  = 8'h55;
  localparam int         FRAME_BITS = 10;
endpackage

// File: rtl/lin_bit_timer.sv
module lin_bit_timer #(
  parameter int OVS = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic tick,
  output logic bit_end,
  output logic mid
);
  localparam int SW = (OVS > 2) ? $clog2(OVS) : 1;
  localparam logic [SW-1:0] LAST = SW'(OVS - 1);
  localparam logic [SW-1:0] HALF = SW'(OVS / 2 - 1);

  logic [SW-1:0] sub;

  always_ff @(posedge clk) begin
    if (rst || !run) sub <= '0;
    else if (tick) sub <= (sub == LAST) ? '0 : sub + 1'b1;
  end

  assign bit_end = run && tick && (sub == LAST);
  assign mid     = run && tick && (sub == HALF);
endmodule

// File: rtl/lin_pid_calc.sv
module lin_pid_calc (
  input  logic [7:0] raw,
  input  logic       par_en,
  output logic [7:0] pid
);
  logic p0, p1;
  assign p0  = raw[0] ^ raw[1] ^ raw[2] ^ raw[4];
  assign p1  = ~(raw[1] ^ raw[3] ^ raw[4] ^ raw[5]);
  assign pid = par_en ? {p1, p0, raw[5:0]} : raw;
endmodule

// File: rtl/lin_hdr_seq.sv
module lin_hdr_seq
  import lin_hdr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       bit_end,
  input  logic [1:0] hdr_sel,
  input  logic [3:0] brk_len,
  input  logic [1:0] dlm_len,
  input  logic [7:0] pid_byte,
  input  logic       send_set,
  output logic       tx,
  output logic       busy,
  output logic       done
);
  localparam int FW = FRAME_BITS;

  hdr_st_t       st;
  logic [1:0]    sel_q;
  logic [3:0]    cnt;
  logic [FW-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_IDLE;
      sel_q <= SEL_BRK;
      cnt   <= '0;
      sh    <= '0;
      tx    <= 1'b1;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (send_set && hdr_sel != SEL_RXONLY) begin
            st    <= ST_BRK;
            sel_q <= hdr_sel;
            cnt   <= brk_len;
            tx    <= 1'b0;
            busy  <= 1'b1;
          end
        end
        ST_BRK: begin
          if (bit_end) begin
            if (cnt == 4'd0) begin
              if (sel_q == SEL_BRK) begin
                st   <= ST_IDLE;
                tx   <= 1'b1;
                busy <= 1'b0;
                done <= 1'b1;
              end else begin
                st  <= ST_DLM;
                tx  <= 1'b1;
                cnt <= {2'b00, dlm_len};
              end
            end else begin
              cnt <= cnt - 4'd1;
            end
          end
        end
        ST_DLM: begin
          if (bit_end) begin
            if (cnt == 4'd0) begin
              st  <= ST_SYN;
              sh  <= {1'b1, SYNC_BYTE, 1'b0};
              tx  <= 1'b0;
              cnt <= 4'(FW - 1);
            end else begin
              cnt <= cnt - 4'd1;
            end
          end
        end
        ST_SYN, ST_PID: begin
          if (bit_end) begin
            if (cnt == 4'd0) begin
              if (st == ST_SYN && sel_q == SEL_PID) begin
                st  <= ST_PID;
                sh  <= {1'b1, pid_byte, 1'b0};
                tx  <= 1'b0;
                cnt <= 4'(FW - 1);
              end else begin
                st   <= ST_IDLE;
                tx   <= 1'b1;
                busy <= 1'b0;
                done <= 1'b1;
              end
            end else begin
              sh  <= {1'b0, sh[FW-1:1]};
              tx  <= sh[1];
              cnt <= cnt - 4'd1;
            end
          end
        end
        default: begin
          st   <= ST_IDLE;
          tx   <= 1'b1;
          busy <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/lin_bit_mon.sv
module lin_bit_mon (
  input  logic clk,
  input  logic rst,
  input  logic mid,
  input  logic busy,
  input  logic tx,
  input  logic rx,
  input  logic clr,
  output logic err
);
  always_ff @(posedge clk) begin
    if (rst) err <= 1'b0;
    else if (mid && busy && (rx != tx)) err <= 1'b1;
    else if (clr) err <= 1'b0;
  end
endmodule

// File: rtl/lin_hdr_gen.sv
module lin_hdr_gen #(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bit_tick,
  input  logic [1:0] hdr_sel,
  input  logic [3:0] brk_len,
  input  logic [1:0] dlm_len,
  input  logic [7:0] pid_in,
  input  logic       par_en,
  input  logic       send_set,
  input  logic       err_clr,
  input  logic       rx_in,
  output logic       tx_out,
  output logic       send_busy,
  output logic       done,
  output logic       bit_err
);
  logic       bit_end, mid;
  logic [7:0] pid_byte;

  lin_bit_timer #(.OVS(OVS)) u_timer (
    .clk(clk), .rst(rst), .run(send_busy), .tick(bit_tick),
    .bit_end(bit_end), .mid(mid)
  );

  lin_pid_calc u_pid (.raw(pid_in), .par_en(par_en), .pid(pid_byte));

  lin_hdr_seq u_seq (
    .clk(clk), .rst(rst), .bit_end(bit_end), .hdr_sel(hdr_sel),
    .brk_len(brk_len), .dlm_len(dlm_len), .pid_byte(pid_byte),
    .send_set(send_set), .tx(tx_out), .busy(send_busy), .done(done)
  );

  lin_bit_mon u_mon (
    .clk(clk), .rst(rst), .mid(mid), .busy(send_busy), .tx(tx_out),
    .rx(rx_in), .clr(err_clr), .err(bit_err)
  );
endmodule

// File: rtl/lin_hdr_gen_chk.sv
module lin_hdr_gen_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] hdr_sel,
  input logic       send_set,
  input logic       err_clr,
  input logic       tx_out,
  input logic       send_busy,
  input logic       done,
  input logic       bit_err
);
  AST_RXONLY_NO_START: assert property (@(posedge clk) disable iff (rst)
    (!send_busy && send_set && hdr_sel == 2'd3) |=> !send_busy); // R2
  AST_START_BREAK: assert property (@(posedge clk) disable iff (rst)
    (!send_busy && send_set && hdr_sel != 2'd3) |=> (send_busy && !tx_out)); // R3
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R8
  AST_DONE_AT_FALL: assert property (@(posedge clk) disable iff (rst)
    done |-> $fell(send_busy)); // R8
  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (rst)
    !send_busy |-> tx_out); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (bit_err && !err_clr) |=> bit_err); // R9
  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (err_clr && !send_busy) |=> !bit_err); // R10
endmodule

bind lin_hdr_gen lin_hdr_gen_chk u_chk (
  .clk(clk), .rst(rst), .hdr_sel(hdr_sel), .send_set(send_set),
  .err_clr(err_clr), .tx_out(tx_out), .send_busy(send_busy),
  .done(done), .bit_err(bit_err)
);

// File: tb/lin_hdr_gen_tb.sv
module lin_hdr_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int OVS = 4;

  logic clk, rst, bit_tick, par_en, send_set, err_clr, rx_in, inj;
  logic [1:0] hdr_sel, dlm_len;
  logic [3:0] brk_len;
  logic [7:0] pid_in;
  logic tx_out, send_busy, done, bit_err;

  int checks = 0;
  int fails  = 0;
  bit exp_q[$];

  assign rx_in = tx_out ^ inj;

  lin_hdr_gen #(.OVS(OVS)) u_dut (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .hdr_sel(hdr_sel),
    .brk_len(brk_len), .dlm_len(dlm_len), .pid_in(pid_in), .par_en(par_en),
    .send_set(send_set), .err_clr(err_clr), .rx_in(rx_in), .tx_out(tx_out),
    .send_busy(send_busy), .done(done), .bit_err(bit_err)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  function automatic logic [7:0] ref_pid(input logic [7:0] r, input logic pen);
    logic a, b;
    a = r[0] ^ r[1] ^ r[2] ^ r[4];
    b = ~(r[1] ^ r[3] ^ r[4] ^ r[5]);
    return pen ? {b, a, r[5:0]} : r;
  endfunction

  task automatic push_frame(input logic [7:0] b);
    exp_q.push_back(1'b0);
    for (int i = 0; i < 8; i++) exp_q.push_back(b[i]);
    exp_q.push_back(1'b1);
  endtask

  // Monitor: samples each bit of a header in mid-bit and compares with scoreboard
  initial begin
    forever begin
      @(posedge send_busy);
      @(negedge clk);
      repeat (OVS / 2 - 1) @(negedge clk);
      while (send_busy) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R3 R4 R5 R6 extra header bit", 1, 0);
        end else begin
          bit e;
          e = exp_q.pop_front();
          chk(tx_out == e, "R3 R4 R5 R6 R7 header bit", int'(tx_out), int'(e));
        end
        repeat (OVS) @(negedge clk);
      end
    end
  end

  // Driver: predicts the header (R3 break, R4 delimiter, R5 sync, R6/R7 identifier)
  task automatic run_hdr(input logic [1:0] sel, input logic [3:0] brk, input logic [1:0] dlm,
                         input logic [7:0] pid, input logic pen, input bit retrig);
    int n;
    for (int i = 0; i <= int'(brk); i++) exp_q.push_back(1'b0);
    if (sel != 2'd0) begin
      for (int i = 0; i <= int'(dlm); i++) exp_q.push_back(1'b1);
      push_frame(8'h55);
      if (sel == 2'd2) push_frame(ref_pid(pid, pen));
    end
    @(negedge clk);
    hdr_sel = sel; brk_len = brk; dlm_len = dlm; pid_in = pid; par_en = pen;
    send_set = 1'b1;
    @(negedge clk);
    send_set = 1'b0;
    chk(send_busy == 1'b1, "R2 busy after send", int'(send_busy), 1);
    chk(tx_out == 1'b0, "R3 break starts", int'(tx_out), 0);
    if (retrig) begin
      repeat (6) @(negedge clk);
      send_set = 1'b1;  // R11: ignored while busy
      @(negedge clk);
      send_set = 1'b0;
    end
    n = 0;
    while (!done && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk(done == 1'b1, "R8 done pulse", int'(done), 1);
    chk(send_busy == 1'b0, "R8 busy self-clears", int'(send_busy), 0);
    chk(tx_out == 1'b1, "R8 line high at end", int'(tx_out), 1);
    @(negedge clk);
    chk(done == 1'b0, "R8 done one cycle", int'(done), 0);
    repeat (OVS) @(negedge clk);
    chk(exp_q.size() == 0, "R11 header length", exp_q.size(), 0);
    chk(send_busy == 1'b0, "R11 no restart", int'(send_busy), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R8 watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    rst = 1'b1; bit_tick = 1'b1; hdr_sel = 2'd0; brk_len = 4'd0; dlm_len = 2'd0;
    pid_in = 8'h00; par_en = 1'b0; send_set = 1'b0; err_clr = 1'b0; inj = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(tx_out == 1'b1, "R1 tx reset", int'(tx_out), 1);
    chk(send_busy == 1'b0, "R1 busy reset", int'(send_busy), 0);
    chk(done == 1'b0, "R1 done reset", int'(done), 0);
    chk(bit_err == 1'b0, "R1 err reset", int'(bit_err), 0);

    // R2: receive-only code does not start
    hdr_sel = 2'd3; send_set = 1'b1;
    @(negedge clk);
    send_set = 1'b0;
    for (int i = 0; i < 3; i++) begin
      chk(send_busy == 1'b0, "R2 rx-only no start", int'(send_busy), 0);
      chk(tx_out == 1'b1, "R2 rx-only line idle", int'(tx_out), 1);
      @(negedge clk);
    end

    run_hdr(2'd0, 4'd0, 2'd0, 8'h00, 1'b0, 1'b0);   // R3 R4 break only
    run_hdr(2'd1, 4'd12, 2'd2, 8'h00, 1'b0, 1'b0);  // R4 R5
    run_hdr(2'd2, 4'd3, 2'd3, 8'hA5, 1'b1, 1'b0);   // R6 R7 parity on
    run_hdr(2'd2, 4'd15, 2'd0, 8'h3C, 1'b0, 1'b1);  // R7 parity off, R11 retrigger
    run_hdr(2'd2, 4'd5, 2'd1, 8'h1F, 1'b1, 1'b0);   // R7
    chk(bit_err == 1'b0, "R9 clean loopback", int'(bit_err), 0);

    // R9: mismatch while idle has no effect
    inj = 1'b1;
    repeat (20) @(negedge clk);
    chk(bit_err == 1'b0, "R9 idle mismatch ignored", int'(bit_err), 0);
    run_hdr(2'd1, 4'd1, 2'd1, 8'h00, 1'b0, 1'b0);
    inj = 1'b0;
    chk(bit_err == 1'b1, "R9 mismatch flagged", int'(bit_err), 1);
    repeat (10) @(negedge clk);
    chk(bit_err == 1'b1, "R9 flag sticky", int'(bit_err), 1);

    // R10: clear
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
    chk(bit_err == 1'b0, "R10 flag cleared", int'(bit_err), 0);

    summary();
  end
endmodule